// File: doc/BRIEF.md
# PCI configuration access translator

This block sits on the host side of a PCI bridge. It turns processor accesses to two registers into configuration transaction requests for a bus engine. The first register is a target pointer, at block offset 0x0. The second is a data window, at block offset 0x4.

The pointer holds the following fields:

| Field | Bits |
|---|---|
| Enable | 31 |
| Bus | 23:16 |
| Device | 15:11 |
| Function | 10:8 |
| Dword register number | 7:2 |

Each access to the window checks these fields and decides what to issue:

- When enable is clear, nothing is issued.
- Device 31 gives a special cycle on a write and an interrupt acknowledge on a read.
- Bus 0 gives a type 0 request, which drives one IDSEL address line chosen by the device number.
- Any other bus gives a type 1 request.

Processor data is little-endian on the bus. A sub-word write places its low bytes on the lanes chosen by the low offset bits, and those lanes also set the byte enables. A sub-word read takes its bytes back from the same lanes into the low end of the result.

Each request to the bus engine is held until the engine acknowledges it. Meanwhile the block signals busy and ignores further processor accesses. A master abort completes with all ones.

Top module: `cfgx_xlate`

## Requirements
- R1: A 4-byte write at offset 0 stores the value masked by 0x80FF_FFFC. A 4-byte read at offset 0 returns the stored value one cycle later, with cpu_done.
- R2: A window access (offset bit 2 = 1) while pointer bit 31 is clear issues no bus request and completes with cpu_done on the next cycle. A read completes with 0xFFFF_FFFF.
- R3: With pointer bus 0 and device below 31, a type 0 request is issued with bus_type1 = 0. Its address is the function in bits 10:8, the register number in bits 7:2 and 00 in bits 1:0. Bit IDSEL_LSB+device is also set when device < NIDSEL; otherwise no upper bit is set.
- R4: With a nonzero pointer bus and device below 31, a type 1 request is issued with bus_type1 = 1. Its address is {8'h00, bus, device, function, register, 2'b01}.
- R5: Device 31 issues bus_kind 3 (special cycle) on a write and bus_kind 2 (interrupt acknowledge) on a read. In both cases bus_type1 = 0 and bus_addr is the pointer value.
- R6: Configuration requests carry bus_kind 0 for a read and 1 for a write.
- R7: cpu_size selects the access width: 0 is 1 byte, 1 is 2 bytes and 2 is 4 bytes. bus_be is the width's low-bit mask shifted left by cpu_off[1:0]. Bit i of bus_be enables bus_wdata[8i+7:8i].
- R8: bus_wdata is cpu_wdata shifted left by 8*cpu_off[1:0].
- R9: The following accesses complete with cpu_err and cpu_done, issue no request and leave the pointer unchanged:
  - size 3 at any offset;
  - a 2-byte access at an odd lane;
  - a 4-byte access at a nonzero lane;
  - an access at offset 0 of any size other than 4 bytes.
- R10: A read completes with bus_rdata shifted right by 8*lane, with only the accessed bytes kept. When bus_abort is set with the acknowledge, the access completes with 0xFFFF_FFFF.
- R11: From the cycle after acceptance until bus_ack is sampled, bus_req and cpu_busy are high and the request fields are held. cpu_done follows one cycle after bus_ack. A cpu_req while busy is ignored.
- R12: After reset the pointer is 0 and bus_req, cpu_busy, cpu_done and cpu_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor access strobe, one cycle |
| cpu_we | input | 1 | 1 = write |
| cpu_off | input | 3 | Byte offset in block |
| cpu_size | input | 2 | Access width code |
| cpu_wdata | input | 32 | Write data, low-aligned |
| cpu_rdata | output | 32 | Read data, valid with cpu_done |
| cpu_done | output | 1 | Access complete pulse |
| cpu_err | output | 1 | Misaligned access, with cpu_done |
| cpu_busy | output | 1 | Bus request outstanding |
| bus_req | output | 1 | Request to bus engine |
| bus_kind | output | 2 | Request kind code |
| bus_type1 | output | 1 | Type 1 configuration request |
| bus_addr | output | 32 | Address phase value |
| bus_be | output | 4 | Byte enables, active high |
| bus_wdata | output | 32 | Lane-placed write data |
| bus_ack | input | 1 | Engine completion |
| bus_rdata | input | 32 | Engine read data |
| bus_abort | input | 1 | Master abort with bus_ack |

## Verification
The bench uses the defaults NIDSEL = 21 and IDSEL_LSB = 11. IDSEL lines then sit on address bits 31:11, so device 1 drives bit 12. Device 25 lies beyond the last line, which makes the no-IDSEL type 0 case reachable. The engine model waits several cycles before acknowledging, so the hold and busy-ignore behaviour is exercised across a real stall.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam int WORD  = 32;
  localparam int NBYTE = WORD / 8;

  localparam logic [WORD-1:0] PTR_KEEP = 32'h80FF_FFFC;

  typedef enum logic [1:0] {
    K_CFG_RD  = 2'd0,
    K_CFG_WR  = 2'd1,
    K_INTACK  = 2'd2,
    K_SPECIAL = 2'd3
  } bus_kind_e;

  localparam logic [1:0] SZ_1 = 2'd0;
  localparam logic [1:0] SZ_2 = 2'd1;
  localparam logic [1:0] SZ_4 = 2'd2;

  function automatic logic [NBYTE-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_1:    return 4'b0001;
      SZ_2:    return 4'b0011;
      SZ_4:    return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic is_aligned(input logic [1:0] sz, input logic [1:0] lane);
    case (sz)
      SZ_1:    return 1'b1;
      SZ_2:    return !lane[0];
      SZ_4:    return lane == 2'd0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [WORD-1:0] place_lanes(input logic [WORD-1:0] d,
                                                  input logic [1:0] lane);
    return d << {lane, 3'b000};
  endfunction

  function automatic logic [WORD-1:0] pick_lanes(input logic [WORD-1:0] d,
                                                 input logic [1:0] lane,
                                                 input logic [1:0] sz);
    logic [WORD-1:0]  t;
    logic [NBYTE-1:0] m;
    logic [WORD-1:0]  r;
    t = d >> {lane, 3'b000};
    m = size_mask(sz);
    for (int i = 0; i < NBYTE; i++) r[8*i +: 8] = m[i] ? t[8*i +: 8] : 8'h00;
    return r;
  endfunction

  function automatic logic [WORD-1:0] idsel_line(input logic [4:0] dev,
                                                 input int nidsel, input int lsb);
    logic [WORD-1:0] r;
    r = '0;
    if (int'(dev) < nidsel) r = 32'd1 << (lsb + int'(dev));
    return r;
  endfunction

endpackage

// File: rtl/cfgx_ptr.sv
module cfgx_ptr
  import cfgx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [WORD-1:0] d,
  output logic [WORD-1:0] q,
  output logic            en,
  output logic [7:0]      bus,
  output logic [4:0]      dev,
  output logic [2:0]      func,
  output logic [5:0]      regn
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= d & PTR_KEEP;
  end

  assign en   = q[31];
  assign bus  = q[23:16];
  assign dev  = q[15:11];
  assign func = q[10:8];
  assign regn = q[7:2];
endmodule

// File: rtl/cfgx_route.sv
module cfgx_route
  import cfgx_pkg::*;
#(
  parameter int NIDSEL    = 21,
  parameter int IDSEL_LSB = 11
) (
  input  logic [WORD-1:0] ptr,
  input  logic [7:0]      bus,
  input  logic [4:0]      dev,
  input  logic [2:0]      func,
  input  logic [5:0]      regn,
  input  logic            is_write,
  output logic [1:0]      kind,
  output logic            type1,
  output logic [WORD-1:0] addr,
  output logic            special
);
  logic remote;

  assign special = dev == 5'h1F;
  assign remote  = bus != 8'h00;

  always_comb begin
    if (special) begin
      kind  = is_write ? K_SPECIAL : K_INTACK;
      type1 = 1'b0;
      addr  = ptr;
    end else if (remote) begin
      kind  = is_write ? K_CFG_WR : K_CFG_RD;
      type1 = 1'b1;
      addr  = {8'h00, bus, dev, func, regn, 2'b01};
    end else begin
      kind  = is_write ? K_CFG_WR : K_CFG_RD;
      type1 = 1'b0;
      addr  = idsel_line(dev, NIDSEL, IDSEL_LSB) | {21'd0, func, regn, 2'b00};
    end
  end

  always_comb begin
    if (special) assert (!type1) else $error("special cycle flagged type 1 (R5)");
  end
endmodule

// File: rtl/cfgx_lanes.sv
module cfgx_lanes
  import cfgx_pkg::*;
(
  input  logic [1:0]       lane,
  input  logic [1:0]       size,
  input  logic [WORD-1:0]  wdata_in,
  input  logic [WORD-1:0]  rdata_in,
  output logic             ok,
  output logic [NBYTE-1:0] be,
  output logic [WORD-1:0]  wdata_out,
  output logic [WORD-1:0]  rdata_out
);
  assign ok        = is_aligned(size, lane);
  assign be        = size_mask(size) << lane;
  assign wdata_out = place_lanes(wdata_in, lane);
  assign rdata_out = pick_lanes(rdata_in, lane, size);

  always_comb begin
    if (ok) assert (be != '0) else $error("aligned access with no byte enable (R7)");
  end
endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate
  import cfgx_pkg::*;
#(
  parameter int NIDSEL    = 21,
  parameter int IDSEL_LSB = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [2:0]  cpu_off,
  input  logic [1:0]  cpu_size,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_done,
  output logic        cpu_err,
  output logic        cpu_busy,
  output logic        bus_req,
  output logic [1:0]  bus_kind,
  output logic        bus_type1,
  output logic [31:0] bus_addr,
  output logic [3:0]  bus_be,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata,
  input  logic        bus_abort
);
  logic            busy_q, we_q, done_q, err_q;
  logic [1:0]      lane_q, size_q, kind_q;
  logic            t1_q;
  logic [WORD-1:0] addr_q, wdata_q, rdata_q;
  logic [3:0]      be_q;

  logic            accept, win_hit, ptr_ok, ptr_wr;
  logic [WORD-1:0] ptr_q;
  logic            ptr_en;
  logic [7:0]      ptr_bus;
  logic [4:0]      ptr_dev;
  logic [2:0]      ptr_func;
  logic [5:0]      ptr_regn;
  logic [1:0]      rt_kind;
  logic            rt_type1, rt_special;
  logic [WORD-1:0] rt_addr;
  logic [1:0]      ln_lane, ln_size;
  logic            ln_ok;
  logic [3:0]      ln_be;
  logic [WORD-1:0] ln_wdata, ln_rdata;

  assign accept  = cpu_req && !busy_q;
  assign win_hit = cpu_off[2];
  assign ptr_ok  = ln_ok && (cpu_size == SZ_4);
  assign ptr_wr  = accept && !win_hit && cpu_we && ptr_ok;
  assign ln_lane = busy_q ? lane_q : cpu_off[1:0];
  assign ln_size = busy_q ? size_q : cpu_size;

  cfgx_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .wr(ptr_wr), .d(cpu_wdata), .q(ptr_q),
    .en(ptr_en), .bus(ptr_bus), .dev(ptr_dev), .func(ptr_func), .regn(ptr_regn)
  );

  cfgx_route #(.NIDSEL(NIDSEL), .IDSEL_LSB(IDSEL_LSB)) u_route (
    .ptr(ptr_q), .bus(ptr_bus), .dev(ptr_dev), .func(ptr_func), .regn(ptr_regn),
    .is_write(cpu_we), .kind(rt_kind), .type1(rt_type1), .addr(rt_addr),
    .special(rt_special)
  );

  cfgx_lanes u_lanes (
    .lane(ln_lane), .size(ln_size), .wdata_in(cpu_wdata), .rdata_in(bus_rdata),
    .ok(ln_ok), .be(ln_be), .wdata_out(ln_wdata), .rdata_out(ln_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      lane_q  <= '0;
      size_q  <= '0;
      kind_q  <= '0;
      t1_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      be_q    <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        rdata_q <= '0;
        if (!win_hit) begin
          done_q <= 1'b1;
          if (!ptr_ok)     err_q   <= 1'b1;
          else if (!cpu_we) rdata_q <= ptr_q;
        end else if (!ln_ok) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end else if (!ptr_en) begin
          done_q <= 1'b1;
          if (!cpu_we) rdata_q <= '1;
        end else begin
          busy_q  <= 1'b1;
          we_q    <= cpu_we;
          lane_q  <= cpu_off[1:0];
          size_q  <= cpu_size;
          kind_q  <= rt_kind;
          t1_q    <= rt_type1;
          addr_q  <= rt_addr;
          be_q    <= ln_be;
          wdata_q <= ln_wdata;
        end
      end else if (busy_q && bus_ack) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        if (bus_abort)  rdata_q <= '1;
        else if (!we_q) rdata_q <= ln_rdata;
      end
    end
  end

  assign cpu_busy  = busy_q;
  assign bus_req   = busy_q;
  assign bus_kind  = kind_q;
  assign bus_type1 = t1_q;
  assign bus_addr  = addr_q;
  assign bus_be    = be_q;
  assign bus_wdata = wdata_q;
  assign cpu_done  = done_q;
  assign cpu_err   = err_q;
  assign cpu_rdata = rdata_q;

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_be) && $stable(bus_kind));

  p_type1_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_type1 |-> bus_addr[1:0] == 2'b01);

  p_err_noreq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> !bus_req && cpu_done);

  p_be_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> ($countones(bus_be) == 1) || ($countones(bus_be) == 2) || ($countones(bus_be) == 4));

  p_abort_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_req && bus_ack && bus_abort) |-> cpu_done && cpu_rdata == 32'hFFFF_FFFF);

  p_done_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |=> cpu_done && !bus_req);
endmodule

// File: tb/tb_cfgx_xlate.sv
module tb_cfgx_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [2:0]  cpu_off = '0;
  logic [1:0]  cpu_size = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_done, cpu_err, cpu_busy;
  logic        bus_req, bus_type1;
  logic [1:0]  bus_kind;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_be;
  logic        bus_ack = 1'b0, bus_abort = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgx_xlate dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_off(cpu_off),
    .cpu_size(cpu_size), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_done(cpu_done), .cpu_err(cpu_err), .cpu_busy(cpu_busy), .bus_req(bus_req),
    .bus_kind(bus_kind), .bus_type1(bus_type1), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_abort(bus_abort)
  );

  typedef struct packed {
    logic [31:0] ptr;
    logic        we;
    logic [1:0]  lane;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [31:0] resp;
    logic        abort;
    logic        req;
    logic [1:0]  kind;
    logic        t1;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] merge;
    logic [31:0] rdata;
    logic        err;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{32'h8000_0814, 1'b1, 2'd0, 2'd2, 32'h1122_3344, 32'h0, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0000_1014, 4'hF, 32'h1122_3344, 32'h0, 1'b0},
    '{32'h8000_081C, 1'b1, 2'd0, 2'd1, 32'hDDCC_BBAA, 32'h0, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0000_101C, 4'h3, 32'hFFFF_BBAA, 32'h0, 1'b0},
    '{32'h8000_081C, 1'b0, 2'd2, 2'd1, 32'h0, 32'h5566_7788, 1'b0, 1'b1, 2'd0, 1'b0, 32'h0000_101C, 4'hC, 32'h0, 32'h0000_5566, 1'b0},
    '{32'h8003_2B08, 1'b0, 2'd3, 2'd0, 32'h0, 32'hA1B2_C3D4, 1'b0, 1'b1, 2'd0, 1'b1, 32'h0003_2B09, 4'h8, 32'h0, 32'h0000_00A1, 1'b0},
    '{32'h8000_1000, 1'b0, 2'd0, 2'd2, 32'h0, 32'h1234_5678, 1'b1, 1'b1, 2'd0, 1'b0, 32'h0000_2000, 4'hF, 32'h0, 32'hFFFF_FFFF, 1'b0},
    '{32'h0000_0814, 1'b1, 2'd0, 2'd2, 32'hCAFE_0000, 32'h0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 4'h0, 32'h0, 32'h0, 1'b0},
    '{32'h0000_0814, 1'b0, 2'd0, 2'd2, 32'h0, 32'h0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 4'h0, 32'h0, 32'hFFFF_FFFF, 1'b0},
    '{32'h8000_F800, 1'b1, 2'd0, 2'd2, 32'h0000_1234, 32'h0, 1'b0, 1'b1, 2'd3, 1'b0, 32'h8000_F800, 4'hF, 32'h0000_1234, 32'h0, 1'b0},
    '{32'h8000_F800, 1'b0, 2'd0, 2'd2, 32'h0, 32'h0000_0042, 1'b0, 1'b1, 2'd2, 1'b0, 32'h8000_F800, 4'hF, 32'h0, 32'h0000_0042, 1'b0},
    '{32'h8000_0814, 1'b1, 2'd1, 2'd1, 32'h1, 32'h0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 4'h0, 32'h0, 32'h0, 1'b1},
    '{32'h8000_0814, 1'b0, 2'd2, 2'd2, 32'h0, 32'h0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 4'h0, 32'h0, 32'h0, 1'b1},
    '{32'h8000_C800, 1'b0, 2'd0, 2'd2, 32'h0, 32'h0BAD_F00D, 1'b0, 1'b1, 2'd0, 1'b0, 32'h0000_0000, 4'hF, 32'h0, 32'h0BAD_F00D, 1'b0},
    '{32'h8000_0DFC, 1'b1, 2'd1, 2'd0, 32'h0000_00EE, 32'h0, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0000_15FC, 4'h2, 32'hFFFF_EEFF, 32'h0, 1'b0},
    '{32'h8000_0814, 1'b0, 2'd0, 2'd3, 32'h0, 32'h0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 4'h0, 32'h0, 32'h0, 1'b1}
  };

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  logic        saw_req, busy_seen, got_done, got_err;
  logic [1:0]  cap_kind;
  logic        cap_t1;
  logic [31:0] cap_addr, cap_wdata, got_rdata;
  logic [3:0]  cap_be;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [2:0] off, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [31:0] resp,
                        input logic ab, input logic poke);
    int held;
    bit acked;
    held = 0;
    acked = 1'b0;
    saw_req = 1'b0;
    busy_seen = 1'b0;
    got_done = 1'b0;
    got_err = 1'b0;
    got_rdata = '0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_off = off; cpu_size = sz; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (bus_ack) bus_ack = 1'b0;
      cpu_req = 1'b0;
      if (cpu_done) begin
        got_done = 1'b1; got_rdata = cpu_rdata; got_err = cpu_err;
        break;
      end
      if (bus_req) begin
        if (!saw_req) begin
          saw_req = 1'b1; busy_seen = cpu_busy;
          cap_kind = bus_kind; cap_t1 = bus_type1; cap_addr = bus_addr;
          cap_be = bus_be; cap_wdata = bus_wdata;
        end
        held++;
        if (poke && held == 2) begin
          cpu_req = 1'b1; cpu_we = 1'b1; cpu_off = 3'd0; cpu_size = 2'd2; cpu_wdata = 32'h0;
        end
        if (held == 3 && !acked) begin
          bus_ack = 1'b1; bus_rdata = resp; bus_abort = ab; acked = 1'b1;
        end
      end
      @(negedge clk);
    end
  endtask

  task automatic ptr_read(output logic [31:0] v);
    access(1'b0, 3'd0, 2'd2, 32'h0, 32'h0, 1'b0, 1'b0);
    v = got_rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, bem, merged;
    repeat (3) @(negedge clk);
    chk("reset bus_req R12", {31'd0, bus_req}, 32'd0);
    chk("reset busy R12", {31'd0, cpu_busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset done/err R12", {30'd0, cpu_done, cpu_err}, 32'd0);
    ptr_read(v);
    chk("reset pointer R12", v, 32'h0);

    for (int k = 0; k < NVEC; k++) begin
      access(1'b1, 3'd0, 2'd2, VECS[k].ptr, 32'h0, 1'b0, 1'b0);
      access(VECS[k].we, {1'b1, VECS[k].lane}, VECS[k].size, VECS[k].wdata,
             VECS[k].resp, VECS[k].abort, 1'b0);
      chk($sformatf("v%0d done R2 R11", k), {31'd0, got_done}, 32'd1);
      chk($sformatf("v%0d request R2 R9", k), {31'd0, saw_req}, {31'd0, VECS[k].req});
      chk($sformatf("v%0d err R9", k), {31'd0, got_err}, {31'd0, VECS[k].err});
      if (VECS[k].req) begin
        chk($sformatf("v%0d kind R5 R6", k), {30'd0, cap_kind}, {30'd0, VECS[k].kind});
        chk($sformatf("v%0d type1 R3 R4", k), {31'd0, cap_t1}, {31'd0, VECS[k].t1});
        chk($sformatf("v%0d addr R3 R4 R5", k), cap_addr, VECS[k].addr);
        chk($sformatf("v%0d be R7", k), {28'd0, cap_be}, {28'd0, VECS[k].be});
        if (VECS[k].we) begin
          for (int b = 0; b < 4; b++) bem[8*b +: 8] = {8{cap_be[b]}};
          merged = (32'hFFFF_FFFF & ~bem) | (cap_wdata & bem);
          chk($sformatf("v%0d merged target R8", k), merged, VECS[k].merge);
        end else begin
          chk($sformatf("v%0d rdata R10", k), got_rdata, VECS[k].rdata);
        end
      end else if (!VECS[k].we && !VECS[k].err) begin
        chk($sformatf("v%0d disabled read R2", k), got_rdata, VECS[k].rdata);
      end
    end

    access(1'b1, 3'd0, 2'd2, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0);
    ptr_read(v);
    chk("pointer readback R1", v, 32'h80FF_FFFC);

    access(1'b1, 3'd0, 2'd1, 32'h8000_0000, 32'h0, 1'b0, 1'b0);
    chk("pointer short write err R9", {31'd0, got_err}, 32'd1);
    ptr_read(v);
    chk("pointer unchanged R9", v, 32'h80FF_FFFC);

    access(1'b1, 3'd0, 2'd2, 32'h8000_0814, 32'h0, 1'b0, 1'b0);
    access(1'b0, 3'd4, 2'd2, 32'h0, 32'h7777_8888, 1'b0, 1'b1);
    chk("busy during request R11", {31'd0, busy_seen}, 32'd1);
    chk("read after stall R11", got_rdata, 32'h7777_8888);
    ptr_read(v);
    chk("access while busy ignored R11", v, 32'h8000_0814);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule